// File: doc/BRIEF.md
# Masked Neighbor Shift Network

This block moves one data word per processing element (PE) to a neighboring PE, for an array of `ROWS x COLS` PEs. The PEs can be treated as one ring of `N = ROWS*COLS` elements or as a two-dimensional array. In both shapes the edges are either open (no link across them) or wrapped. A start pulse captures the shape, wrap flag, direction, activity mask, step count and per-PE send words. The block then performs one neighbor shift per clock for the requested number of steps. After the last step it raises a one-cycle done pulse.

Each PE has two registers. The travelling word is loaded from the send input at start. The receive register is the block's output. The send operand and the receive destination are therefore separate, and a start never overwrites the receive register. A PE takes in the travelling word from its upstream neighbor only when it is active, has a link in that direction, and that neighbor is also active. Otherwise both of its registers hold. This gating turns an active sector of a closed ring into an open chain: the first PE of the sector keeps its value, and the last PE's outgoing word has nowhere to land.

Top module: `nbr_shift_net`

## Requirements
- R1: After reset, every receive word is zero, `busy` is 0 and `done` is 0.
- R2: Ring shape (`shape`=0) with `dir[0]`=0, all PEs active and wrap on. One step sets the receive word of PE i to the send word of PE (i-1) mod N, so PE 0 receives from PE N-1. In ring shape only `dir[0]` is used.
- R3: Ring shape with `dir[0]`=1 and wrap on. One step sets the receive word of PE i to the send word of PE (i+1) mod N.
- R4: A PE whose upstream neighbor is inactive keeps its previous receive word. In a closed ring with a contiguous active sector, the first PE of the sector keeps its receive word and every other PE of the sector receives normally.
- R5: An inactive PE never changes its receive word, whatever its neighbors send.
- R6: Ring shape with wrap off is an open chain. With `dir[0]`=0, PE 0 has no link and keeps its receive word. With `dir[0]`=1, PE N-1 has no link and keeps its receive word.
- R7: Array shape (`shape`=1) with wrap off uses PE index i = r*COLS + c. Direction codes are: 0 sends to column c+1, 1 sends to column c-1, 2 sends to row r+1, 3 sends to row r-1. A PE whose source lies outside the array keeps its receive word.
- R8: Array shape with wrap on is a torus. Column sources wrap mod COLS and row sources wrap mod ROWS.
- R9: A shift of k steps is k single-step shifts. A PE with no receive in a step keeps its travelling word and passes it on again in later steps. After k full-ring steps, PE i holds the send word of PE (i-k) mod N.
- R10: For k>0, `busy` is high for exactly k cycles after the start edge, and `done` pulses for one cycle right after. For k=0, `done` pulses in the cycle after start and no receive word changes.
- R11: While `busy` is high, `start` and every other control or data input are ignored. The result equals the result of the operation already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| shape | input | 1 | 0 = ring of N PEs, 1 = ROWS x COLS array |
| wrap | input | 1 | 1 = edges wrap around, 0 = open edges |
| dir | input | 2 | Shift direction code (see R2, R3, R7) |
| steps | input | STEP_W | Number of single-step shifts |
| act_mask | input | ROWS*COLS | Per-PE activity, bit i for PE i |
| send_data | input | ROWS*COLS*W | Per-PE send word, PE i at bits i*W +: W |
| rcv_data | output | ROWS*COLS*W | Per-PE receive register, PE i at bits i*W +: W |
| busy | output | 1 | Shift steps in progress |
| done | output | 1 | One-cycle pulse after the last step |

## Verification
The assertions assume that reset is applied before the first operation. They also assume that configuration is sampled only when `start` meets an idle controller, so the frozen-configuration and hold properties rely on inputs changing only through that capture. The stimulus drives `start` as a single-cycle pulse on the falling edge. It waits for `done` before starting anything new, except in the one scenario that deliberately toggles every input while `busy` is high to show that nothing leaks in. Step counts stay within `STEP_W` bits. Masks include full, sector-shaped and sparse patterns so that both gating conditions (inactive receiver and inactive upstream) are exercised.

// File: rtl/msn_pkg.sv
package msn_pkg;
  typedef enum logic [1:0] {
    DIR_INC  = 2'd0,  // toward higher index / column + 1
    DIR_DEC  = 2'd1,  // toward lower index / column - 1
    DIR_ROWP = 2'd2,  // toward row + 1
    DIR_ROWM = 2'd3   // toward row - 1
  } dir_e;
endpackage

// File: rtl/msn_link_map.sv
module msn_link_map #(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int N     = ROWS * COLS,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic               shape,
  input  logic               wrap,
  input  msn_pkg::dir_e      dir_sel,
  output logic [N*IDX_W-1:0] src_flat,
  output logic [N-1:0]       link_ok
);
  import msn_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_pe
    localparam int RI = i / COLS;
    localparam int CI = i % COLS;
    // source index seen by PE i for each direction, with its edge flag
    localparam int SRC_RINC = (i == 0) ? N - 1 : i - 1;
    localparam bit EDG_RINC = (i == 0);
    localparam int SRC_RDEC = (i == N - 1) ? 0 : i + 1;
    localparam bit EDG_RDEC = (i == N - 1);
    localparam int SRC_GINC = (CI == 0) ? RI * COLS + COLS - 1 : i - 1;
    localparam bit EDG_GINC = (CI == 0);
    localparam int SRC_GDEC = (CI == COLS - 1) ? RI * COLS : i + 1;
    localparam bit EDG_GDEC = (CI == COLS - 1);
    localparam int SRC_GRP  = (RI == 0) ? (ROWS - 1) * COLS + CI : i - COLS;
    localparam bit EDG_GRP  = (RI == 0);
    localparam int SRC_GRM  = (RI == ROWS - 1) ? CI : i + COLS;
    localparam bit EDG_GRM  = (RI == ROWS - 1);

    logic [IDX_W-1:0] src;
    logic             edge_hit;

    always_comb begin
      if (!shape) begin
        if (dir_sel == DIR_INC || dir_sel == DIR_ROWP) begin
          src = IDX_W'(SRC_RINC); edge_hit = EDG_RINC;
        end else begin
          src = IDX_W'(SRC_RDEC); edge_hit = EDG_RDEC;
        end
      end else begin
        case (dir_sel)
          DIR_INC:  begin src = IDX_W'(SRC_GINC); edge_hit = EDG_GINC; end
          DIR_DEC:  begin src = IDX_W'(SRC_GDEC); edge_hit = EDG_GDEC; end
          DIR_ROWP: begin src = IDX_W'(SRC_GRP);  edge_hit = EDG_GRP;  end
          default:  begin src = IDX_W'(SRC_GRM);  edge_hit = EDG_GRM;  end
        endcase
      end
    end

    assign src_flat[i*IDX_W +: IDX_W] = src;
    assign link_ok[i] = !edge_hit || wrap;
  end
endmodule

// File: rtl/msn_step_ctrl.sv
module msn_step_ctrl #(
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [STEP_W-1:0] steps,
  output logic              load,
  output logic              step,
  output logic              busy,
  output logic              done
);
  logic [STEP_W-1:0] remaining;

  assign load = start && !busy;
  assign step = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        remaining <= steps;
        busy      <= (steps != '0);
        done      <= (steps == '0);
      end else if (busy) begin
        remaining <= remaining - 1'b1;
        if (remaining == STEP_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_LAST_STEP_DONE: assert property (@(posedge clk) disable iff (rst)
    busy && remaining == STEP_W'(1) |=> done && !busy); // R10
  AST_MID_STEP_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy && remaining != STEP_W'(1) |=> busy && !done); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    busy |-> !load); // R11
endmodule

// File: rtl/msn_pe_cell.sv
module msn_pe_cell #(
  parameter int W     = 8,
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic             act_self,
  input  logic             has_link,
  input  logic [IDX_W-1:0] src_idx,
  input  logic [N-1:0]     act_mask,
  input  logic [N*W-1:0]   carry_bus,
  input  logic [W-1:0]     send_val,
  output logic [W-1:0]     carry_q,
  output logic [W-1:0]     rcv_q
);
  logic [W-1:0] up_val;
  logic         rx;

  assign up_val = carry_bus[int'(src_idx)*W +: W];
  assign rx     = step && act_self && has_link && act_mask[src_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= '0;
      rcv_q   <= '0;
    end else begin
      if (load)    carry_q <= send_val;
      else if (rx) carry_q <= up_val;
      if (rx)      rcv_q   <= up_val;
    end
  end

  AST_INACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !act_self |=> $stable(rcv_q)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(rcv_q)); // R10
  AST_NO_UPSTREAM_HOLD: assert property (@(posedge clk) disable iff (rst)
    step && !act_mask[src_idx] |=> $stable(rcv_q)); // R4
endmodule

// File: rtl/nbr_shift_net.sv
module nbr_shift_net #(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int W      = 8,
  parameter int STEP_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   shape,
  input  logic                   wrap,
  input  logic [1:0]             dir,
  input  logic [STEP_W-1:0]      steps,
  input  logic [ROWS*COLS-1:0]   act_mask,
  input  logic [ROWS*COLS*W-1:0] send_data,
  output logic [ROWS*COLS*W-1:0] rcv_data,
  output logic                   busy,
  output logic                   done
);
  import msn_pkg::*;

  localparam int N     = ROWS * COLS;
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic             load, step;
  logic             shape_q, wrap_q;
  dir_e             dir_q;
  logic [N-1:0]     mask_q;
  logic [N*IDX_W-1:0] src_flat;
  logic [N-1:0]     link_ok;
  logic [N*W-1:0]   carry_bus;

  msn_step_ctrl #(.STEP_W(STEP_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .steps(steps),
    .load(load), .step(step), .busy(busy), .done(done)
  );

  // operation configuration captured when a start is taken
  always_ff @(posedge clk) begin
    if (rst) begin
      shape_q <= 1'b0;
      wrap_q  <= 1'b0;
      dir_q   <= DIR_INC;
      mask_q  <= '0;
    end else if (load) begin
      shape_q <= shape;
      wrap_q  <= wrap;
      dir_q   <= dir_e'(dir);
      mask_q  <= act_mask;
    end
  end

  msn_link_map #(.ROWS(ROWS), .COLS(COLS), .N(N), .IDX_W(IDX_W)) u_map (
    .shape(shape_q), .wrap(wrap_q), .dir_sel(dir_q),
    .src_flat(src_flat), .link_ok(link_ok)
  );

  for (genvar i = 0; i < N; i++) begin : g_cell
    msn_pe_cell #(.W(W), .N(N), .IDX_W(IDX_W)) u_cell (
      .clk(clk), .rst(rst), .load(load), .step(step),
      .act_self(mask_q[i]), .has_link(link_ok[i]),
      .src_idx(src_flat[i*IDX_W +: IDX_W]), .act_mask(mask_q),
      .carry_bus(carry_bus), .send_val(send_data[i*W +: W]),
      .carry_q(carry_bus[i*W +: W]), .rcv_q(rcv_data[i*W +: W])
    );
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(mask_q) && $stable(dir_q) && $stable(shape_q) && $stable(wrap_q)); // R11
endmodule

// File: tb/test_nbr_shift_net.sv
`timescale 1ns/1ps
module test_nbr_shift_net;
  localparam int ROWS = 4, COLS = 4, W = 8, STEP_W = 4;
  localparam int N = ROWS * COLS;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, shape = 1'b0, wrap = 1'b0;
  logic [1:0] dir = 2'd0;
  logic [STEP_W-1:0] steps = '0;
  logic [N-1:0] act_mask = '0;
  logic [N*W-1:0] send_data = '0;
  logic [N*W-1:0] rcv_data;
  logic busy, done;

  int n_chk = 0, n_bad = 0;
  logic [W-1:0] m_rcv [N];
  logic [W-1:0] m_car [N];
  logic [W-1:0] m_snd [N];

  always #10 clk = ~clk;

  nbr_shift_net #(.ROWS(ROWS), .COLS(COLS), .W(W), .STEP_W(STEP_W)) i_nbr_shift_net (
    .clk(clk), .rst(rst), .start(start), .shape(shape), .wrap(wrap), .dir(dir),
    .steps(steps), .act_mask(act_mask), .send_data(send_data),
    .rcv_data(rcv_data), .busy(busy), .done(done)
  );

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int rx_of(int i);
    return int'(rcv_data[i*W +: W]);
  endfunction

  // source PE feeding PE i, or -1 when no link
  function automatic int src_of(int i, bit shp, bit wr, int d);
    int r, c;
    r = i / COLS; c = i % COLS;
    if (!shp) begin
      if (d % 2 == 0) return (i == 0) ? (wr ? N - 1 : -1) : i - 1;
      else            return (i == N - 1) ? (wr ? 0 : -1) : i + 1;
    end
    case (d)
      0: return (c == 0) ? (wr ? r*COLS + COLS - 1 : -1) : i - 1;
      1: return (c == COLS - 1) ? (wr ? r*COLS : -1) : i + 1;
      2: return (r == 0) ? (wr ? (ROWS-1)*COLS + c : -1) : i - COLS;
      default: return (r == ROWS - 1) ? (wr ? c : -1) : i + COLS;
    endcase
  endfunction

  task automatic model(bit shp, bit wr, int d, int k, logic [N-1:0] m);
    logic [W-1:0] nc [N];
    for (int i = 0; i < N; i++) m_car[i] = m_snd[i];
    for (int s = 0; s < k; s++) begin
      for (int i = 0; i < N; i++) begin
        int sr;
        sr = src_of(i, shp, wr, d);
        nc[i] = m_car[i];
        if (m[i] && sr >= 0 && m[sr]) begin
          nc[i] = m_car[sr];
          m_rcv[i] = m_car[sr];
        end
      end
      for (int i = 0; i < N; i++) m_car[i] = nc[i];
    end
  endtask

  task automatic fill_send(int salt);
    for (int i = 0; i < N; i++) begin
      m_snd[i] = W'(i * 37 + salt * 11 + 5);
      send_data[i*W +: W] = m_snd[i];
    end
  endtask

  task automatic run_op(bit shp, bit wr, int d, int k, logic [N-1:0] m, int salt);
    int t;
    fill_send(salt);
    @(negedge clk);
    shape = shp; wrap = wr; dir = 2'(d); steps = STEP_W'(k); act_mask = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 100) begin @(negedge clk); t++; end
    model(shp, wr, d, k, m);
  endtask

  task automatic cmp_all(string req);
    for (int i = 0; i < N; i++) chk(req, rx_of(i), int'(m_rcv[i]));
  endtask

  task automatic t_reset();
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    for (int i = 0; i < N; i++) begin chk("R1 rcv", rx_of(i), 0); m_rcv[i] = '0; end
  endtask

  task automatic t_ring_fwd();
    run_op(1'b0, 1'b1, 0, 1, '1, 1);
    chk("R2 pe0 from pe N-1", rx_of(0), int'(m_snd[N-1]));
    chk("R2 pe5 from pe4", rx_of(5), int'(m_snd[4]));
    cmp_all("R2");
  endtask

  task automatic t_ring_back();
    run_op(1'b0, 1'b1, 1, 1, '1, 2);
    chk("R3 pe N-1 from pe0", rx_of(N-1), int'(m_snd[0]));
    cmp_all("R3");
  endtask

  task automatic t_sector();
    logic [W-1:0] keep3;
    logic [N-1:0] m;
    m = '0;
    for (int i = 3; i <= 8; i++) m[i] = 1'b1;
    keep3 = m_rcv[3];
    run_op(1'b0, 1'b1, 0, 1, m, 3);
    chk("R4 sector head keeps", rx_of(3), int'(keep3));
    chk("R4 sector pe4 from pe3", rx_of(4), int'(m_snd[3]));
    chk("R5 pe9 after pe8 sends", rx_of(9), int'(m_rcv[9]));
    cmp_all("R4");
    run_op(1'b0, 1'b1, 3, 1, 16'h5A5A, 4);
    cmp_all("R5");
  endtask

  task automatic t_open_ring();
    logic [W-1:0] keep;
    keep = m_rcv[0];
    run_op(1'b0, 1'b0, 0, 1, '1, 5);
    chk("R6 pe0 no link", rx_of(0), int'(keep));
    cmp_all("R6");
    keep = m_rcv[N-1];
    run_op(1'b0, 1'b0, 1, 1, '1, 6);
    chk("R6 pe N-1 no link", rx_of(N-1), int'(keep));
    cmp_all("R6");
  endtask

  task automatic t_grid_open();
    for (int d = 0; d < 4; d++) begin
      run_op(1'b1, 1'b0, d, 1, '1, 7 + d);
      cmp_all("R7");
    end
    run_op(1'b1, 1'b0, 2, 1, '1, 12);
    chk("R7 row+1 pe5 from pe1", rx_of(5), int'(m_snd[1]));
    chk("R7 row0 pe2 keeps", rx_of(2), int'(m_rcv[2]));
  endtask

  task automatic t_torus();
    for (int d = 0; d < 4; d++) begin
      run_op(1'b1, 1'b1, d, 1, '1, 13 + d);
      cmp_all("R8");
    end
    run_op(1'b1, 1'b1, 0, 1, '1, 20);
    chk("R8 col wrap pe4 from pe7", rx_of(4), int'(m_snd[7]));
    run_op(1'b1, 1'b1, 3, 1, '1, 21);
    chk("R8 row wrap pe12 from pe0", rx_of(12), int'(m_snd[0]));
  endtask

  task automatic t_multi();
    run_op(1'b0, 1'b1, 0, 3, '1, 22);
    chk("R9 pe1 from pe14", rx_of(1), int'(m_snd[14]));
    cmp_all("R9");
    run_op(1'b0, 1'b0, 0, 4, 16'h0FF0, 23);
    chk("R9 open chain pe6 gets pe4 repeated", rx_of(6), int'(m_snd[4]));
    cmp_all("R9");
    run_op(1'b1, 1'b0, 1, 2, '1, 24);
    cmp_all("R9");
  endtask

  task automatic t_timing();
    int nb;
    logic [W-1:0] snap [N];
    fill_send(30);
    @(negedge clk);
    shape = 1'b0; wrap = 1'b1; dir = 2'd0; steps = STEP_W'(4); act_mask = '1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nb = 0;
    while (busy && nb < 50) begin
      chk("R10 no done while busy", int'(done), 0);
      nb++; @(negedge clk);
    end
    chk("R10 busy cycles", nb, 4);
    chk("R10 done pulse", int'(done), 1);
    model(1'b0, 1'b1, 0, 4, '1);
    cmp_all("R10");
    @(negedge clk);
    chk("R10 done one cycle", int'(done), 0);
    for (int i = 0; i < N; i++) snap[i] = rcv_data[i*W +: W];
    fill_send(31);
    steps = '0; act_mask = '1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 zero steps done", int'(done), 1);
    chk("R10 zero steps busy", int'(busy), 0);
    for (int i = 0; i < N; i++) chk("R10 zero steps no change", rx_of(i), int'(snap[i]));
  endtask

  task automatic t_busy_ignore();
    int t;
    fill_send(40);
    @(negedge clk);
    shape = 1'b0; wrap = 1'b1; dir = 2'd1; steps = STEP_W'(3); act_mask = '1; start = 1'b1;
    @(negedge clk);
    start = 1'b1; shape = 1'b1; wrap = 1'b0; dir = 2'd2; steps = STEP_W'(9);
    act_mask = 16'h000F;
    for (int i = 0; i < N; i++) send_data[i*W +: W] = W'(200 + i);
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 100) begin @(negedge clk); t++; end
    model(1'b0, 1'b1, 1, 3, '1);
    cmp_all("R11");
    @(negedge clk);
    chk("R11 idle after", int'(busy), 0);
  endtask

  initial begin
    #3000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ring_fwd();
    t_ring_back();
    t_sector();
    t_open_ring();
    t_grid_open();
    t_torus();
    t_multi();
    t_timing();
    t_busy_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule